// File: doc/BRIEF.md
# Double-Edge Input Capture and Realignment

This block takes a parallel group of pins that carry double-data-rate data and converts each lane into two single-rate bits for the core. One flip-flop per lane samples the pin on the rising clock edge. A second flip-flop per lane samples the pin on the falling clock edge. A level-sensitive latch passes the falling-edge sample on while the clock is low and holds it while the clock is high. Core logic clocked on the rising edge therefore sees both halves of each bit period at the same moment.

The high word holds the datum that was present during the half-cycle just before a rising edge. The low word holds the datum from the half-cycle that follows that edge. Core logic reads them together as one pair at the next rising edge. The raw falling-edge flip-flop output is also brought out so the sample can be observed before it reaches the latch. An asynchronous active-high clear forces every storage element to zero. The lane count is the parameter `LANES`.

Top module: `ddr_in_capture`

## Requirements
- R1: `hi_word` takes the value of `pin_d` at each rising edge of `clk`. It keeps that value until the next rising edge, including across the falling edge.
- R2: `fall_q` takes the value of `pin_d` at each falling edge of `clk`. It keeps that value until the next falling edge.
- R3: While `clk` is low, `lo_word` follows `fall_q`. While `clk` is high, `lo_word` holds the value it had when the clock rose.
- R4: Let a datum be on `pin_d` before rising edge k, and let the next datum be on `pin_d` before the following falling edge. Just before rising edge k+1, `hi_word` carries the first datum and `lo_word` carries the second, so they form one pair.
- R5: While `clr` is high, `hi_word`, `lo_word` and `fall_q` are all zero. This takes effect at once, with no clock edge.
- R6: Each bit position of `pin_d` is captured independently into the same bit position of `hi_word`, `lo_word` and `fall_q`. Bit i of the pin only ever appears in bit i of the outputs.
- R7: After `clr` is released, the first valid pair appears after one rising edge and the falling edge that follows it. Until then the outputs stay at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Capture clock; both edges are used |
| clr | input | 1 | Asynchronous clear, active high |
| pin_d | input | LANES | Double-data-rate input lanes |
| hi_word | output | LANES | Rising-edge sample, aligned to the rising edge |
| lo_word | output | LANES | Falling-edge sample after the latch, aligned to the rising edge |
| fall_q | output | LANES | Raw falling-edge flip-flop output |

## Verification
If a rising-edge flip-flop captured on the wrong edge or the wrong lane, `hi_word` would show the wrong datum half a cycle after that edge. If the latch had the wrong polarity or did not hold, `lo_word` would differ from the previous pair during the high phase, or differ from `fall_q` in the low phase just before the next rising edge. All of these faults appear within one clock period of the edge that caused them. The bench therefore samples each output in both clock phases of every vector. A faulty clear shows up as non-zero outputs one time step after `clr` rises, with no clock edge needed.

// File: rtl/ddr_in_capture.sv
module ddr_in_capture #(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             clr,
  input  logic [LANES-1:0] pin_d,
  output logic [LANES-1:0] hi_word,
  output logic [LANES-1:0] lo_word,
  output logic [LANES-1:0] fall_q
);

  logic [LANES-1:0] rise_r;
  logic [LANES-1:0] fall_r;
  logic [LANES-1:0] lo_lat;

  always_ff @(posedge clk or posedge clr) begin
    if (clr) rise_r <= '0;
    else     rise_r <= pin_d;
  end

  always_ff @(negedge clk or posedge clr) begin
    if (clr) fall_r <= '0;
    else     fall_r <= pin_d;
  end

  always_latch begin
    if (clr)       lo_lat <= '0;
    else if (!clk) lo_lat <= fall_r;
  end

  assign hi_word = rise_r;
  assign fall_q  = fall_r;
  assign lo_word = lo_lat;

endmodule

// File: rtl/ddr_in_capture_chk.sv
module ddr_in_capture_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             clr,
  input logic [LANES-1:0] pin_d,
  input logic [LANES-1:0] hi_word,
  input logic [LANES-1:0] lo_word,
  input logic [LANES-1:0] fall_q
);

  logic             primed;
  logic [LANES-1:0] pin_at_rise;

  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      primed      <= 1'b0;
      pin_at_rise <= '0;
    end else begin
      primed      <= 1'b1;
      pin_at_rise <= pin_d;
    end
  end

  a_r1_hi_capture: assert property (@(posedge clk) disable iff (clr)
    primed |-> hi_word == $past(pin_d));

  a_r1_hi_held_at_fall: assert property (@(negedge clk) disable iff (clr)
    primed |-> hi_word == pin_at_rise);

  a_r3_lo_matches_fall_at_rise: assert property (@(posedge clk) disable iff (clr)
    lo_word == fall_q);

  a_r5_clear_zero: assert property (@(posedge clk)
    clr |-> (hi_word == '0 && lo_word == '0 && fall_q == '0));

endmodule

bind ddr_in_capture ddr_in_capture_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .clr(clr), .pin_d(pin_d),
  .hi_word(hi_word), .lo_word(lo_word), .fall_q(fall_q)
);

// File: tb/ddr_in_capture_test.sv
`timescale 1ns/1ps
module ddr_in_capture_test;
  localparam int LANES = 4;
  localparam int NV = 10;
  localparam logic [7:0] VEC [NV] = '{
    8'hF0, 8'h0F, 8'hA5, 8'h5A, 8'h33, 8'h33, 8'h18, 8'h81, 8'hFF, 8'h00
  };

  logic clk = 1'b0;
  logic clr;
  logic [LANES-1:0] pin_d;
  logic [LANES-1:0] hi_word, lo_word, fall_q;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ddr_in_capture #(.LANES(LANES)) uut (
    .clk(clk), .clr(clr), .pin_d(pin_d),
    .hi_word(hi_word), .lo_word(lo_word), .fall_q(fall_q)
  );

  task automatic chk(input string req, input logic [LANES-1:0] act, input logic [LANES-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  initial begin
    #50000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [LANES-1:0] prev_lo;
    clr = 1'b1;
    pin_d = '0;
    #1;
    chk("R5 reset hi", hi_word, '0);
    chk("R5 reset lo", lo_word, '0);
    chk("R5 reset fall", fall_q, '0);
    #9;
    clr = 1'b0;
    pin_d = VEC[0][7:4];
    prev_lo = '0;
    for (int j = 0; j < NV; j++) begin
      @(posedge clk); #1;
      pin_d = VEC[j][3:0];
      #1;
      chk("R1 hi after rise", hi_word, VEC[j][7:4]);
      chk("R3 lo held in high phase", lo_word, prev_lo);
      @(negedge clk); #1;
      pin_d = (j + 1 < NV) ? VEC[j+1][7:4] : 4'h9;
      #1;
      chk("R2 fall sample", fall_q, VEC[j][3:0]);
      chk("R4 pair lo", lo_word, VEC[j][3:0]);
      chk("R4 pair hi held", hi_word, VEC[j][7:4]);
      prev_lo = VEC[j][3:0];
    end

    // R5: clear in the middle of the high phase, no clock edge needed
    @(posedge clk); #1;
    pin_d = 4'hC;
    clr = 1'b1;
    #1;
    chk("R5 clear hi", hi_word, '0);
    chk("R5 clear lo", lo_word, '0);
    chk("R5 clear fall", fall_q, '0);
    @(negedge clk); #1;
    chk("R5 held through fall", fall_q, '0);
    #1;
    clr = 1'b0;
    pin_d = 4'h6;
    // R7: first pair after release
    @(posedge clk); #1;
    pin_d = 4'h9;
    #1;
    chk("R7 first hi", hi_word, 4'h6);
    chk("R7 lo still zero", lo_word, '0);
    @(negedge clk); #2;
    chk("R7 first lo", lo_word, 4'h9);
    // R6: single lane toggled, other lanes stay put
    pin_d = 4'b0100;
    @(posedge clk); #1;
    pin_d = 4'b0001;
    #1;
    chk("R6 lane isolation hi", hi_word, 4'b0100);
    @(negedge clk); #2;
    chk("R6 lane isolation lo", lo_word, 4'b0001);
    chk("R6 lane isolation fall", fall_q, 4'b0001);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule